// File: doc/BRIEF.md
# SD Card Single-Line Data Path Controller

This block drives the single data line of an SD-style host during a write, and keeps time during a read. A transfer starts when the enable input rises. For a write, the block waits a fixed gap and then frames the outgoing words into data tokens. Each token has a low start bit, the payload sent MSB first, and a high end bit. In block mode a CRC16 sits in front of the end bit; in stream mode there is no CRC. In block mode, after each token the block waits for the card's CRC status and for the card to release D0. It then starts the next block or returns to idle.

Words come from a buffer over a valid/ready pair. Ready is high for exactly one cycle before the first bit of each word is driven, and the word is taken on that clock edge. The serializer cannot stall, so it applies no back-pressure of its own. If valid is low while ready is high, that is an underrun: the block sets the FIFO error flag and returns to idle. Read transfers are not serialized here. The block only waits in a receive state under the data timer until the receive side reports end of data.

Three sticky flags report errors: FIFO underrun, CRC failure and data timeout. Each flag is cleared by a one-cycle pulse on its own clear bit.

Top module: `sd_dat_ctrl`

## Requirements
- R1: After reset the data line is high, ready is low, all flags are 0 and `xfer_active` is low. Whenever the block is idle, the line is high and ready is low.
- R2: A rising `xfer_en` in idle latches the configuration. With `xfer_dir`=0 the block holds a two-cycle pre-send gap with the line high, so the start bit (0) is driven in the third cycle after the edge that samples the rise. With `xfer_dir`=1 the block enters the receive wait.
- R3: Payload words are shifted out MSB first, one bit per clock, directly after the start bit. `fifo_ready` is high during the start-bit cycle for the first word, and during the last bit of a word for each following word.
- R4: In block mode (`stream_mode`=0), after min(`blk_words`, words left) words (a `blk_words` of 0 acts as 1), the block sends 16 CRC bits MSB first and then a 1 end bit. The CRC uses polynomial 0x1021, starts from 0 and covers the payload bits of that token. The block then waits in busy with the line high.
- R5: After a block is released, the block starts the next token after the same two-cycle gap. If no words remain, it returns to idle one cycle after the release and drives no further bits.
- R6: In stream mode, at each word boundary the block sends another word only if `xfer_en` is high and words remain. Otherwise it sends the end bit straight after the payload, with no CRC, and returns to idle.
- R7: If `fifo_ready` is high while `fifo_valid` is low, flag bit 0 (FIFO error) is set and the block returns to idle.
- R8: In busy, a CRC status with `crc_stat_ok`=0 sets flag bit 1 (CRC fail) and returns the block to idle.
- R9: In busy, after a positive CRC status, the block stays busy while `d0_in` is low. The first cycle with `d0_in` high moves it to the pre-send gap.
- R10: The data timer runs only in busy and in the receive wait, and restarts from zero on each entry. After `tmo_cycles` cycles in one of those states (0 meaning 2^16), flag bit 2 (timeout) is set and the block goes idle. A CRC status, a busy release or `rx_end` in that same final cycle takes priority over the timeout.
- R11: In the receive wait, `rx_end` returns the block to idle without setting any flag.
- R12: The flags hold their value until `flag_clr` pulses on the matching bit. If a set and a clear land in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_en | input | 1 | Transfer enable; its rising edge starts a transfer, and in stream mode it gates more words |
| xfer_dir | input | 1 | 0 = send to card, 1 = receive wait |
| stream_mode | input | 1 | 0 = block tokens, 1 = stream token |
| blk_words | input | 8 | Words per block |
| total_words | input | 10 | Total words in the transfer |
| tmo_cycles | input | 16 | Data timeout period in cycles |
| fifo_data | input | 32 | Word offered by the buffer |
| fifo_valid | input | 1 | Buffer holds a word |
| fifo_ready | output | 1 | Word taken on this edge |
| crc_stat_valid | input | 1 | Card CRC status present this cycle |
| crc_stat_ok | input | 1 | CRC status is positive |
| d0_in | input | 1 | D0 level, low while the card is busy |
| rx_end | input | 1 | Receive side saw end of data |
| flag_clr | input | 3 | Per-flag clear pulse |
| dat_out | output | 1 | Serial data line |
| flags | output | 3 | Bit 0 FIFO error, bit 1 CRC fail, bit 2 timeout |
| xfer_active | output | 1 | Block is not idle |

## Verification
The hardest case to reach from the ports is a flag set and a flag clear landing in the same cycle. A timeout only fires on the one edge chosen by the timer. The bench therefore holds the timeout clear bit high through an entire receive wait, so the clear is certain to coincide with the setting edge, and it checks that the flag is high on the sample right after that edge and low one cycle later. The bench also drops `rx_end` into exactly the final cycle of the timeout window, to check that the exit takes priority over the timeout.

// File: rtl/sd_dp_pkg.sv
`timescale 1ns/1ps
package sd_dp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT_S, ST_SEND, ST_BUSY, ST_WAIT_R
  } dp_state_e;

  typedef enum logic [1:0] {
    PH_START, PH_DATA, PH_CRC, PH_END
  } dp_phase_e;

  localparam int NUM_FLAGS = 3;
  localparam int FLAG_FIFO = 0;
  localparam int FLAG_CRC  = 1;
  localparam int FLAG_TMO  = 2;
  localparam int CRC_W     = 16;
  localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
endpackage

// File: rtl/sd_crc16_ser.sv
`timescale 1ns/1ps
module sd_crc16_ser import sd_dp_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic upd,
  input  logic shift,
  input  logic din,
  output logic msb
);
  logic [CRC_W-1:0] crc_q;
  logic fb;

  assign fb  = crc_q[CRC_W-1] ^ din;
  assign msb = crc_q[CRC_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= '0;
    else if (clr)   crc_q <= '0;
    else if (upd)   crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
    else if (shift) crc_q <= {crc_q[CRC_W-2:0], 1'b0};
  end
endmodule

// File: rtl/sd_dat_timer.sv
`timescale 1ns/1ps
module sd_dat_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expired,
  output logic [TMO_W-1:0] cnt
);
  assign expired = run && (cnt == (limit - TMO_W'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else           cnt <= cnt + TMO_W'(1);
  end
endmodule

// File: rtl/sd_flag_bank.sv
`timescale 1ns/1ps
module sd_flag_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sd_dat_ctrl.sv
`timescale 1ns/1ps
module sd_dat_ctrl import sd_dp_pkg::*; #(
  parameter int WORD_W     = 32,
  parameter int LEN_W      = 10,
  parameter int BLK_W      = 8,
  parameter int TMO_W      = 16,
  parameter int WAIT_S_CYC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xfer_en,
  input  logic                 xfer_dir,
  input  logic                 stream_mode,
  input  logic [BLK_W-1:0]     blk_words,
  input  logic [LEN_W-1:0]     total_words,
  input  logic [TMO_W-1:0]     tmo_cycles,
  input  logic [WORD_W-1:0]    fifo_data,
  input  logic                 fifo_valid,
  output logic                 fifo_ready,
  input  logic                 crc_stat_valid,
  input  logic                 crc_stat_ok,
  input  logic                 d0_in,
  input  logic                 rx_end,
  input  logic [NUM_FLAGS-1:0] flag_clr,
  output logic                 dat_out,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 xfer_active
);
  localparam int CNT_W = ($clog2(WORD_W) > 4) ? $clog2(WORD_W) : 4;
  localparam int WS_W  = $clog2(WAIT_S_CYC + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] LAST_CRC = CNT_W'(CRC_W - 1);
  localparam logic [WS_W-1:0]  LAST_WS  = WS_W'(WAIT_S_CYC - 1);

  dp_state_e           state_q;
  dp_phase_e           phase_q;
  logic [CNT_W-1:0]    bit_q;
  logic [WS_W-1:0]     ws_q;
  logic [LEN_W-1:0]    left_q, blk_left_q, blk_ext, first_blk;
  logic [BLK_W-1:0]    blk_cfg_q;
  logic [TMO_W-1:0]    tmo_q, tmr_cnt;
  logic [WORD_W-1:0]   shreg_q;
  logic                stream_q, en_q, ok_seen_q;
  logic                start_req, last_bit, more_words, underrun;
  logic                crc_neg, busy_release, rx_done, tmr_run, tmr_exp;
  logic                crc_clr, crc_upd, crc_shift, crc_msb;
  logic [NUM_FLAGS-1:0] flag_set;

  // Decode of the current state into events
  always_comb begin
    start_req    = (state_q == ST_IDLE) && xfer_en && !en_q;
    last_bit     = (bit_q == LAST_BIT);
    more_words   = stream_q ? ((left_q != '0) && xfer_en) : (blk_left_q != '0);
    fifo_ready   = (state_q == ST_SEND) &&
                   ((phase_q == PH_START) || ((phase_q == PH_DATA) && last_bit && more_words));
    underrun     = fifo_ready && !fifo_valid;
    crc_neg      = (state_q == ST_BUSY) && crc_stat_valid && !crc_stat_ok;
    busy_release = (state_q == ST_BUSY) && !crc_neg && d0_in &&
                   (ok_seen_q || (crc_stat_valid && crc_stat_ok));
    rx_done      = (state_q == ST_WAIT_R) && rx_end;
    tmr_run      = (state_q == ST_BUSY) || (state_q == ST_WAIT_R);
    flag_set[FLAG_FIFO] = underrun;
    flag_set[FLAG_CRC]  = crc_neg;
    flag_set[FLAG_TMO]  = tmr_exp && !crc_neg && !busy_release && !rx_done;
    blk_ext      = (blk_cfg_q == '0) ? LEN_W'(1) : LEN_W'(blk_cfg_q);
    first_blk    = (left_q < blk_ext) ? left_q : blk_ext;
    crc_clr      = (state_q == ST_SEND) && (phase_q == PH_START);
    crc_upd      = (state_q == ST_SEND) && (phase_q == PH_DATA);
    crc_shift    = (state_q == ST_SEND) && (phase_q == PH_CRC);
    xfer_active  = (state_q != ST_IDLE);
  end

  // Line level for each state and token phase
  always_comb begin
    dat_out = 1'b1;
    if (state_q == ST_SEND) begin
      case (phase_q)
        PH_START: dat_out = 1'b0;
        PH_DATA:  dat_out = shreg_q[WORD_W-1];
        PH_CRC:   dat_out = crc_msb;
        default:  dat_out = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      phase_q    <= PH_START;
      bit_q      <= '0;
      ws_q       <= '0;
      left_q     <= '0;
      blk_left_q <= '0;
      blk_cfg_q  <= '0;
      tmo_q      <= '0;
      shreg_q    <= '0;
      stream_q   <= 1'b0;
      en_q       <= 1'b0;
      ok_seen_q  <= 1'b0;
    end else begin
      en_q <= xfer_en;
      unique case (state_q)
        ST_IDLE: if (start_req) begin
          stream_q  <= stream_mode;
          blk_cfg_q <= blk_words;
          left_q    <= total_words;
          tmo_q     <= tmo_cycles;
          ws_q      <= '0;
          state_q   <= xfer_dir ? ST_WAIT_R : ST_WAIT_S;
        end
        ST_WAIT_S: begin
          if (left_q == '0) state_q <= ST_IDLE;
          else if (ws_q == LAST_WS) begin
            state_q    <= ST_SEND;
            phase_q    <= PH_START;
            blk_left_q <= first_blk;
          end else ws_q <= ws_q + WS_W'(1);
        end
        ST_SEND: begin
          if (underrun) state_q <= ST_IDLE;
          else begin
            unique case (phase_q)
              PH_START: begin
                shreg_q    <= fifo_data;
                left_q     <= left_q - LEN_W'(1);
                blk_left_q <= blk_left_q - LEN_W'(1);
                bit_q      <= '0;
                phase_q    <= PH_DATA;
              end
              PH_DATA: begin
                if (!last_bit) begin
                  shreg_q <= shreg_q << 1;
                  bit_q   <= bit_q + CNT_W'(1);
                end else if (more_words) begin
                  shreg_q    <= fifo_data;
                  left_q     <= left_q - LEN_W'(1);
                  blk_left_q <= blk_left_q - LEN_W'(1);
                  bit_q      <= '0;
                end else begin
                  bit_q   <= '0;
                  phase_q <= stream_q ? PH_END : PH_CRC;
                end
              end
              PH_CRC: begin
                bit_q <= bit_q + CNT_W'(1);
                if (bit_q == LAST_CRC) phase_q <= PH_END;
              end
              default: begin
                phase_q   <= PH_START;
                ok_seen_q <= 1'b0;
                state_q   <= stream_q ? ST_IDLE : ST_BUSY;
              end
            endcase
          end
        end
        ST_BUSY: begin
          if (crc_stat_valid && crc_stat_ok) ok_seen_q <= 1'b1;
          if (crc_neg) state_q <= ST_IDLE;
          else if (busy_release) begin
            state_q <= ST_WAIT_S;
            ws_q    <= '0;
          end else if (tmr_exp) state_q <= ST_IDLE;
        end
        ST_WAIT_R: if (rx_done || tmr_exp) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  sd_crc16_ser u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd),
    .shift(crc_shift), .din(shreg_q[WORD_W-1]), .msb(crc_msb)
  );

  sd_dat_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .limit(tmo_q),
    .expired(tmr_exp), .cnt(tmr_cnt)
  );

  sd_flag_bank #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .q(flags)
  );
endmodule

// File: rtl/sd_dat_ctrl_chk.sv
`timescale 1ns/1ps
module sd_dat_ctrl_chk import sd_dp_pkg::*; #(
  parameter int TMO_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input dp_state_e            state,
  input logic [TMO_W-1:0]     tcnt,
  input logic [NUM_FLAGS-1:0] flags,
  input logic [NUM_FLAGS-1:0] flag_clr,
  input logic                 dat_out,
  input logic                 fifo_ready,
  input logic                 xfer_active
);
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_active |-> (dat_out && !fifo_ready)); // R1
  AST_GAP_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SEND && $past(state) == ST_WAIT_S) |-> ($past(state, 2) == ST_WAIT_S)); // R2
  AST_POP_ONLY_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |-> (state == ST_SEND)); // R3
  AST_UNDERRUN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FLAG_FIFO]) |-> (state == ST_IDLE)); // R7
  AST_CRCFAIL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FLAG_CRC]) |-> (state == ST_IDLE)); // R8
  AST_TIMER_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
    (tcnt != '0) |-> ($past(state) == ST_BUSY || $past(state) == ST_WAIT_R)); // R10
  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[FLAG_TMO]) |-> (state == ST_IDLE)); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|flags) |=> ((($past(flags) & ~$past(flag_clr)) & ~flags) == '0)); // R12
endmodule

bind sd_dat_ctrl sd_dat_ctrl_chk #(.TMO_W(TMO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state_q), .tcnt(tmr_cnt), .flags(flags),
  .flag_clr(flag_clr), .dat_out(dat_out), .fifo_ready(fifo_ready),
  .xfer_active(xfer_active)
);

// File: tb/sim_sd_dat_ctrl.sv
`timescale 1ns/1ps
module sim_sd_dat_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        xfer_en = 0, xfer_dir = 0, stream_mode = 0;
  logic [7:0]  blk_words = 8'd1;
  logic [9:0]  total_words = 10'd0;
  logic [15:0] tmo_cycles = 16'd2000;
  logic [31:0] fifo_data = '0;
  logic        fifo_valid = 0, crc_stat_valid = 0, crc_stat_ok = 0, d0_in = 1, rx_end = 0;
  logic [2:0]  flag_clr = '0;
  logic        fifo_ready, dat_out, xfer_active;
  logic [2:0]  flags;
  int errs = 0, nchk = 0, fidx = 0, favail = 0;
  bit pend = 0;

  always #2.5 clk = ~clk;

  sd_dat_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .xfer_dir(xfer_dir),
    .stream_mode(stream_mode), .blk_words(blk_words), .total_words(total_words),
    .tmo_cycles(tmo_cycles), .fifo_data(fifo_data), .fifo_valid(fifo_valid),
    .fifo_ready(fifo_ready), .crc_stat_valid(crc_stat_valid), .crc_stat_ok(crc_stat_ok),
    .d0_in(d0_in), .rx_end(rx_end), .flag_clr(flag_clr), .dat_out(dat_out),
    .flags(flags), .xfer_active(xfer_active)
  );

  function automatic logic [31:0] wv(int i);
    return (32'(i + 1) * 32'h9E3779B9) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [15:0] crcw(logic [15:0] c, logic [31:0] w);
    logic fb;
    for (int i = 31; i >= 0; i--) begin
      fb = c[15] ^ w[i];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  // Buffer model: word index advances after each edge that took a word
  always begin
    @(negedge clk);
    if (pend) fidx++;
    fifo_data  = wv(fidx);
    fifo_valid = (fidx < favail);
    #1;
    pend = fifo_ready & fifo_valid;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic smp();
    @(negedge clk);
  endtask

  task automatic setup(int total, int blk, bit strm, bit dir, int tmo, int avail);
    fidx = 0; favail = avail;
    total_words = 10'(total); blk_words = 8'(blk);
    stream_mode = strm; xfer_dir = dir; tmo_cycles = 16'(tmo);
  endtask

  task automatic wait_start(string tag);
    xfer_en = 1;
    smp(); chk({tag, " gap1"}, dat_out, 1);
    smp(); chk({tag, " gap2"}, dat_out, 1);
    smp(); chk({tag, " start"}, dat_out, 0);
  endtask

  task automatic read_word(output logic [31:0] w);
    w = '0;
    for (int b = 0; b < 32; b++) begin smp(); w = {w[30:0], dat_out}; end
  endtask

  task automatic clear_all();
    flag_clr = 3'b111; smp(); flag_clr = 3'b000;
  endtask

  task automatic blk_run(int total, int blk);
    int sent, nb, be;
    logic [15:0] c; logic [31:0] w;
    sent = 0;
    be = (blk == 0) ? 1 : blk;
    setup(total, blk, 0, 0, 2000, total);
    wait_start("R2 block");
    xfer_en = 0;
    while (sent < total) begin
      nb = (total - sent < be) ? total - sent : be;
      c = '0;
      for (int k = 0; k < nb; k++) begin
        read_word(w); chk("R3 word", w, wv(sent));
        c = crcw(c, wv(sent)); sent++;
      end
      w = '0;
      for (int b = 0; b < 16; b++) begin smp(); w = {w[30:0], dat_out}; end
      chk("R4 crc", w[15:0], c);
      smp(); chk("R4 end bit", dat_out, 1); d0_in = 0;
      smp(); crc_stat_valid = 1; crc_stat_ok = 1;
      smp(); crc_stat_valid = 0;
      smp(); chk("R9 busy held by d0", {xfer_active, dat_out, fifo_ready}, 3'b110);
      d0_in = 1; smp(); smp();
      if (sent < total) begin smp(); chk("R5 next token start", dat_out, 0); end
      else chk("R5 back to idle", xfer_active, 0);
    end
    chk("R5 no flags", flags, 0);
  endtask

  task automatic str_run(int total, int drop);
    int n; logic [31:0] w;
    n = (drop >= 0 && drop + 1 < total) ? drop + 1 : total;
    setup(total, 1, 1, 0, 2000, total);
    wait_start("R6 stream");
    for (int k = 0; k < n; k++) begin
      w = '0;
      for (int b = 0; b < 32; b++) begin
        smp(); w = {w[30:0], dat_out};
        if (k == drop && b == 4) xfer_en = 0;
      end
      chk("R6 word", w, wv(k));
    end
    smp(); chk("R6 end bit after payload", dat_out, 1);
    smp(); chk("R6 idle without crc", xfer_active, 0);
    xfer_en = 0; smp();
  endtask

  task automatic under_run(int avail);
    setup(3, 3, 0, 0, 2000, avail);
    wait_start("R7");
    xfer_en = 0;
    repeat (avail * 32) smp();
    smp(); chk("R7 underrun to idle", {xfer_active, dat_out, flags[0]}, 3'b011);
    flag_clr = 3'b001; smp(); flag_clr = 3'b000;
    chk("R12 clear pulse", flags[0], 0);
  endtask

  task automatic one_block_to_busy(int tmo);
    logic [31:0] w;
    setup(1, 1, 0, 0, tmo, 1);
    wait_start("R2 single");
    xfer_en = 0;
    read_word(w);
    repeat (16) smp();
    smp(); chk("R4 end before busy", dat_out, 1); d0_in = 0;
  endtask

  task automatic wr_tmo(int t);
    setup(0, 1, 0, 1, t, 0);
    xfer_en = 1;
    repeat (t) smp();
    chk("R10 receive no early timeout", {xfer_active, flags[2]}, 2'b10);
    smp(); chk("R10 receive timeout", {xfer_active, flags[2]}, 2'b01);
    xfer_en = 0; clear_all();
  endtask

  task automatic wr_end(int t, int at);
    setup(0, 1, 0, 1, t, 0);
    xfer_en = 1;
    repeat (at) smp();
    rx_end = 1; smp(); rx_end = 0;
    chk("R11 end of data idle", {xfer_active, flags}, 4'b0000);
    xfer_en = 0; smp();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; nchk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end

  initial begin
    repeat (3) smp();
    rst_n = 1;
    smp();
    chk("R1 reset state", {dat_out, fifo_ready, flags, xfer_active}, 6'b100000);

    for (int blk = 1; blk <= 3; blk++)
      for (int tot = 1; tot <= 4; tot++) blk_run(tot, blk);
    blk_run(2, 0);

    for (int tot = 1; tot <= 3; tot++) str_run(tot, -1);
    str_run(4, 1);
    str_run(3, 0);

    under_run(0);
    under_run(1);

    one_block_to_busy(2000);
    smp(); crc_stat_valid = 1; crc_stat_ok = 0;
    smp(); crc_stat_valid = 0;
    chk("R8 crc fail to idle", {xfer_active, flags}, 4'b0010);
    d0_in = 1; clear_all();

    for (int t = 1; t <= 4; t += 3) begin
      one_block_to_busy(t);
      repeat (t) smp();
      chk("R10 busy no early timeout", {xfer_active, flags[2]}, 2'b10);
      smp(); chk("R10 busy timeout", {xfer_active, flags[2]}, 2'b01);
      d0_in = 1; clear_all();
    end

    for (int t = 1; t <= 5; t += 2) wr_tmo(t);
    wr_end(10, 3);
    wr_end(3, 3);

    // set and clear land together: set must win
    flag_clr = 3'b100;
    setup(0, 1, 0, 1, 3, 0);
    xfer_en = 1;
    repeat (3) smp();
    smp(); chk("R12 set beats clear", flags[2], 1);
    smp(); chk("R12 clear after", flags[2], 0);
    flag_clr = 3'b000; xfer_en = 0; smp();
    chk("R1 idle line", {dat_out, fifo_ready, xfer_active}, 3'b100);

    $display("  Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule